// File: doc/BRIEF.md
# Limited-Pointer Coherence Directory with Software Overflow

This block is the directory controller of one memory node in a distributed shared-memory machine. For each memory line homed at the node it records which remote caches hold a copy, using a small fixed number of hardware sharer pointers per line. Read requests add the requester to the line's sharer set. Write requests invalidate every other holder, count the acknowledgements, and only then grant exclusive ownership. A read to a line owned exclusively by another node fetches the dirty copy back before both nodes become sharers.

When a line needs more sharers than it has hardware pointers, the controller does not broadcast or evict. It marks the line as extended and traps to the local processor. Software then tracks the extra sharers in local memory and signals completion with a resume pulse. From then on every request to an extended line takes the trap path. A global zero-pointer mode sends every request through the trap path, so software handles all of coherence. The controller serves one request at a time and holds `reqReady` low while an invalidation, fetch or trap is in progress.

Top module: `ptr_directory`

## Requirements
- R1: Each line holds up to NUM_PTRS (default 4) sharer pointers, filled from the lowest free slot. A read from a new node to an uncached or shared line with a free slot is granted (`grantValid`=1, `grantWrite`=0, `grantNode`=requester) for exactly one cycle, the cycle after the request is accepted.
- R2: A read from a node not yet recorded, to a shared line whose pointers are all in use, is not granted. In the cycle after acceptance, `trapValid`=1, `trapOverflow`=1, and `trapLine`/`trapNode` show the request. The trap holds, with `reqReady`=0, until the cycle after `resumeValid` is sampled.
- R3: After an overflow, every later request to that line, read or write, traps with `trapOverflow`=0 and is not granted. Other lines are not affected.
- R4: While `zeroPtrMode`=1, every accepted request traps with `trapOverflow`=0, gets no grant, and leaves the line's entry unchanged.
- R5: A write to a line held by other nodes raises `invValid` from the cycle after acceptance. It names one holder per cycle in ascending slot order and skips the requester. Each `ackValid` cycle counts one acknowledgement. The write grant (`grantWrite`=1) appears the second cycle after the edge that samples the last acknowledgement, never earlier. The line then becomes exclusive to the writer.
- R6: A repeated read from a node already recorded for the line is granted without using a new pointer. A later fifth distinct reader still overflows.
- R7: A read to a line held exclusively by another node raises `fetchValid` with `fetchNode`=owner from the cycle after acceptance until `wbValid`. The read grant appears in the cycle after `wbValid` is sampled. The line then holds the owner in slot 0 and the requester in slot 1.
- R8: A write to an uncached line, to a line owned exclusively by the writer, or to a line whose only sharer is the writer is granted in the cycle after acceptance, with no invalidations.
- R9: `reqReady` is 1 only when the controller is idle. A request presented while it is 0 is not accepted and produces no grant or trap.
- R10: After reset, `reqReady`=1, all other outputs are 0, and every line is uncached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| zeroPtrMode | input | 1 | Route every request to the trap path |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write (exclusive) request, 0 = read |
| reqLine | input | LINE_W | Line index of the request |
| reqNode | input | NODE_W | Requesting node ID |
| reqReady | output | 1 | Controller idle, request is accepted this cycle |
| ackValid | input | 1 | One invalidation acknowledgement |
| wbValid | input | 1 | Owner write-back after a fetch |
| resumeValid | input | 1 | Software handler finished the trap |
| invValid | output | 1 | Invalidation to send this cycle |
| invNode | output | NODE_W | Target of the invalidation |
| fetchValid | output | 1 | Fetch/downgrade request outstanding |
| fetchNode | output | NODE_W | Current exclusive owner to fetch from |
| grantValid | output | 1 | One-cycle grant pulse |
| grantWrite | output | 1 | Grant is exclusive |
| grantNode | output | NODE_W | Granted node |
| trapValid | output | 1 | Trap outstanding to the local processor |
| trapOverflow | output | 1 | Trap caused by pointer overflow |
| trapLine | output | LINE_W | Line of the trapped request |
| trapNode | output | NODE_W | Node of the trapped request |

## Verification
The bench drives each request on a falling edge and samples at the next falling edge after the accepting rising edge. That is where grants, traps, the first invalidation and the fetch are due. Invalidation targets then advance by one per clock. The exclusive grant is checked absent one sample after the last acknowledgement and present one sample later. The fetch-path read grant is checked one sample after the write-back pulse. Trap and fetch levels are checked again after idle cycles to show they hold until resume or write-back. Entry contents that have no output of their own are observed through later requests: a repeat read followed by a fifth reader, and a write that lists the merged sharers.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    DS_UNC = 2'd0,
    DS_SHR = 2'd1,
    DS_EXC = 2'd2
  } dirState_t;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_INVAL = 2'd1,
    CS_FETCH = 2'd2,
    CS_TRAP  = 2'd3
  } ctlState_t;

  // Entry facts for the incoming request, computed by the datapath
  typedef struct packed {
    dirState_t state;
    logic      extended;
    logic      present;
    logic      full;
    logic      invNeeded;
  } dirLookup_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latch;    // capture request, operands come from the inputs
    logic addPtr;   // add requester to lowest free slot, line shared
    logic markExt;  // line overflowed into software
    logic ovf;      // value captured into trapOverflow
    logic setExcl;  // line exclusive to operand node
    logic loadInv;  // load invalidation mask and ack count
    logic popInv;   // retire the current invalidation
    logic mergeWb;  // owner plus requester become sharers
    logic grant;
    logic grantWr;
  } dirStrobe_t;

endpackage

// File: rtl/dir_datapath.sv
module dir_datapath
  import dir_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int NUM_NODES = 16,
  parameter int NUM_PTRS  = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [$clog2(NUM_LINES)-1:0] reqLine,
  input  logic [$clog2(NUM_NODES)-1:0] reqNode,
  input  logic                         ackValid,
  input  dirStrobe_t                   strb,
  output dirLookup_t                   lk,
  output logic                         invEmpty,
  output logic                         pendZero,
  output logic                         invValid,
  output logic [$clog2(NUM_NODES)-1:0] invNode,
  output logic [$clog2(NUM_NODES)-1:0] fetchNode,
  output logic                         grantValid,
  output logic                         grantWrite,
  output logic [$clog2(NUM_NODES)-1:0] grantNode,
  output logic                         trapOverflow,
  output logic [$clog2(NUM_LINES)-1:0] trapLine,
  output logic [$clog2(NUM_NODES)-1:0] trapNode
);

  localparam int LINE_W = $clog2(NUM_LINES);
  localparam int NODE_W = $clog2(NUM_NODES);
  localparam int SLOT_W = (NUM_PTRS > 1) ? $clog2(NUM_PTRS) : 1;
  localparam int CNT_W  = $clog2(NUM_PTRS + 1);

  dirState_t           entState [NUM_LINES];
  logic [NUM_PTRS-1:0] entValid [NUM_LINES];
  logic [NODE_W-1:0]   entPtr   [NUM_LINES][NUM_PTRS];
  logic                entExt   [NUM_LINES];

  logic [LINE_W-1:0]   latLine;
  logic [NODE_W-1:0]   latNode;
  logic [NUM_PTRS-1:0] invMask;
  logic [CNT_W-1:0]    pending;

  logic [LINE_W-1:0]   opLine;
  logic [NODE_W-1:0]   opNode;
  logic [NUM_PTRS-1:0] hitMask;
  logic [NUM_PTRS-1:0] otherMask;
  logic [CNT_W-1:0]    otherCnt;
  logic [SLOT_W-1:0]   freeSlot;
  logic [SLOT_W-1:0]   invSlot;
  logic [NUM_PTRS-1:0] invOneHot;

  assign opLine = strb.latch ? reqLine : latLine;
  assign opNode = strb.latch ? reqNode : latNode;

  // Match of the incoming node against each pointer slot
  for (genvar s = 0; s < NUM_PTRS; s++) begin : g_match
    assign hitMask[s] = entValid[reqLine][s] && (entPtr[reqLine][s] == reqNode);
  end

  assign otherMask = entValid[reqLine] & ~hitMask;

  always_comb begin
    otherCnt = '0;
    for (int s = 0; s < NUM_PTRS; s++) otherCnt = otherCnt + CNT_W'(otherMask[s]);
  end

  // Lowest free slot of the operand line, lowest pending invalidation
  always_comb begin
    freeSlot = '0;
    for (int s = NUM_PTRS - 1; s >= 0; s--)
      if (!entValid[opLine][s]) freeSlot = SLOT_W'(s);
  end

  always_comb begin
    invSlot = '0;
    for (int s = NUM_PTRS - 1; s >= 0; s--)
      if (invMask[s]) invSlot = SLOT_W'(s);
    invOneHot = '0;
    if (|invMask) invOneHot[invSlot] = 1'b1;
  end

  always_comb begin
    lk.state     = entState[reqLine];
    lk.extended  = entExt[reqLine];
    lk.present   = |hitMask;
    lk.full      = &entValid[reqLine];
    lk.invNeeded = |otherMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int l = 0; l < NUM_LINES; l++) begin
        entState[l] <= DS_UNC;
        entValid[l] <= '0;
        entExt[l]   <= 1'b0;
        for (int s = 0; s < NUM_PTRS; s++) entPtr[l][s] <= '0;
      end
      latLine      <= '0;
      latNode      <= '0;
      invMask      <= '0;
      pending      <= '0;
      grantValid   <= 1'b0;
      grantWrite   <= 1'b0;
      grantNode    <= '0;
      trapOverflow <= 1'b0;
    end else begin
      grantValid <= strb.grant;
      if (strb.grant) begin
        grantWrite <= strb.grantWr;
        grantNode  <= opNode;
      end
      if (strb.latch) begin
        latLine      <= reqLine;
        latNode      <= reqNode;
        trapOverflow <= strb.ovf;
      end
      if (strb.addPtr) begin
        entState[opLine]           <= DS_SHR;
        entValid[opLine][freeSlot] <= 1'b1;
        entPtr[opLine][freeSlot]   <= opNode;
      end
      if (strb.markExt) entExt[opLine] <= 1'b1;
      if (strb.setExcl) begin
        entState[opLine]  <= DS_EXC;
        entValid[opLine]  <= NUM_PTRS'(1);
        entPtr[opLine][0] <= opNode;
      end
      if (strb.mergeWb) begin
        entState[opLine]  <= DS_SHR;
        entValid[opLine]  <= NUM_PTRS'(3);
        entPtr[opLine][1] <= opNode;
      end
      if (strb.loadInv) begin
        invMask <= otherMask;
        pending <= otherCnt;
      end else begin
        if (strb.popInv) invMask <= invMask & ~invOneHot;
        if (ackValid && pending != '0) pending <= pending - 1'b1;
      end
    end
  end

  assign invEmpty  = ~|invMask;
  assign pendZero  = (pending == '0);
  assign invValid  = |invMask;
  assign invNode   = entPtr[latLine][invSlot];
  assign fetchNode = entPtr[latLine][0];
  assign trapLine  = latLine;
  assign trapNode  = latNode;

  // R5: exclusivity never granted while invalidations remain to be sent
  a_r5_no_grant_during_inval: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> !grantValid);

  // R2: control declares overflow only on a line whose pointers are all used
  a_r2_overflow_only_full: assert property (@(posedge clk) disable iff (!rstN)
    strb.markExt |-> lk.full);

endmodule

// File: rtl/dir_control.sv
module dir_control
  import dir_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       zeroPtrMode,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  dirLookup_t lk,
  input  logic       invEmpty,
  input  logic       pendZero,
  input  logic       wbValid,
  input  logic       resumeValid,
  output dirStrobe_t strb,
  output logic       reqReady,
  output logic       fetchValid,
  output logic       trapValid
);

  ctlState_t state, nextState;

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      CS_IDLE: begin
        if (reqValid) begin
          strb.latch = 1'b1;
          if (zeroPtrMode || lk.extended) begin
            nextState = CS_TRAP;
          end else if (reqWrite) begin
            if (lk.invNeeded) begin
              strb.loadInv = 1'b1;
              nextState    = CS_INVAL;
            end else begin
              strb.setExcl = 1'b1;
              strb.grant   = 1'b1;
              strb.grantWr = 1'b1;
            end
          end else begin
            unique case (lk.state)
              DS_UNC: begin
                strb.addPtr = 1'b1;
                strb.grant  = 1'b1;
              end
              DS_SHR: begin
                if (lk.present) begin
                  strb.grant = 1'b1;
                end else if (!lk.full) begin
                  strb.addPtr = 1'b1;
                  strb.grant  = 1'b1;
                end else begin
                  strb.markExt = 1'b1;
                  strb.ovf     = 1'b1;
                  nextState    = CS_TRAP;
                end
              end
              default: begin
                if (lk.present) strb.grant = 1'b1;
                else            nextState  = CS_FETCH;
              end
            endcase
          end
        end
      end
      CS_INVAL: begin
        strb.popInv = 1'b1;
        if (invEmpty && pendZero) begin
          strb.setExcl = 1'b1;
          strb.grant   = 1'b1;
          strb.grantWr = 1'b1;
          nextState    = CS_IDLE;
        end
      end
      CS_FETCH: begin
        if (wbValid) begin
          strb.mergeWb = 1'b1;
          strb.grant   = 1'b1;
          nextState    = CS_IDLE;
        end
      end
      default: begin
        if (resumeValid) nextState = CS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= CS_IDLE;
    else       state <= nextState;
  end

  assign reqReady   = (state == CS_IDLE);
  assign fetchValid = (state == CS_FETCH);
  assign trapValid  = (state == CS_TRAP);

  // R2: a trap stays raised until the handler resumes
  a_r2_trap_held: assert property (@(posedge clk) disable iff (!rstN)
    trapValid && !resumeValid |=> trapValid);

  // R7: the fetch stays raised until the owner writes back
  a_r7_fetch_held: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && !wbValid |=> fetchValid);

  // R9: no new request taken while a trap or fetch is pending
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid || fetchValid) |-> !reqReady);

endmodule

// File: rtl/ptr_directory.sv
module ptr_directory
  import dir_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int NUM_NODES = 16,
  parameter int NUM_PTRS  = 4,
  localparam int LINE_W   = $clog2(NUM_LINES),
  localparam int NODE_W   = $clog2(NUM_NODES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              zeroPtrMode,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [LINE_W-1:0] reqLine,
  input  logic [NODE_W-1:0] reqNode,
  output logic              reqReady,
  input  logic              ackValid,
  input  logic              wbValid,
  input  logic              resumeValid,
  output logic              invValid,
  output logic [NODE_W-1:0] invNode,
  output logic              fetchValid,
  output logic [NODE_W-1:0] fetchNode,
  output logic              grantValid,
  output logic              grantWrite,
  output logic [NODE_W-1:0] grantNode,
  output logic              trapValid,
  output logic              trapOverflow,
  output logic [LINE_W-1:0] trapLine,
  output logic [NODE_W-1:0] trapNode
);

  dirStrobe_t strb;
  dirLookup_t lk;
  logic       invEmpty;
  logic       pendZero;

  dir_control i_control (
    .clk         (clk),
    .rstN        (rstN),
    .zeroPtrMode (zeroPtrMode),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .lk          (lk),
    .invEmpty    (invEmpty),
    .pendZero    (pendZero),
    .wbValid     (wbValid),
    .resumeValid (resumeValid),
    .strb        (strb),
    .reqReady    (reqReady),
    .fetchValid  (fetchValid),
    .trapValid   (trapValid)
  );

  dir_datapath #(
    .NUM_LINES (NUM_LINES),
    .NUM_NODES (NUM_NODES),
    .NUM_PTRS  (NUM_PTRS)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .reqLine      (reqLine),
    .reqNode      (reqNode),
    .ackValid     (ackValid),
    .strb         (strb),
    .lk           (lk),
    .invEmpty     (invEmpty),
    .pendZero     (pendZero),
    .invValid     (invValid),
    .invNode      (invNode),
    .fetchNode    (fetchNode),
    .grantValid   (grantValid),
    .grantWrite   (grantWrite),
    .grantNode    (grantNode),
    .trapOverflow (trapOverflow),
    .trapLine     (trapLine),
    .trapNode     (trapNode)
  );

  // R4: in zero-pointer mode an accepted request traps and is not granted
  a_r4_zero_ptr_traps: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && zeroPtrMode |=> trapValid && !grantValid);

endmodule

// File: tb/test_ptr_directory.sv
module test_ptr_directory;

  localparam int CLK_PERIOD = 10;
  localparam int LINE_W = 3;
  localparam int NODE_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic zeroPtrMode = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [LINE_W-1:0] reqLine = '0;
  logic [NODE_W-1:0] reqNode = '0;
  logic ackValid = 1'b0;
  logic wbValid = 1'b0;
  logic resumeValid = 1'b0;
  logic reqReady, invValid, fetchValid, grantValid, grantWrite, trapValid, trapOverflow;
  logic [NODE_W-1:0] invNode, fetchNode, grantNode, trapNode;
  logic [LINE_W-1:0] trapLine;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_directory i_ptr_directory (
    .clk(clk), .rstN(rstN), .zeroPtrMode(zeroPtrMode),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqLine(reqLine), .reqNode(reqNode),
    .reqReady(reqReady), .ackValid(ackValid), .wbValid(wbValid), .resumeValid(resumeValid),
    .invValid(invValid), .invNode(invNode), .fetchValid(fetchValid), .fetchNode(fetchNode),
    .grantValid(grantValid), .grantWrite(grantWrite), .grantNode(grantNode),
    .trapValid(trapValid), .trapOverflow(trapOverflow), .trapLine(trapLine), .trapNode(trapNode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Returns at the falling edge after the accepting rising edge
  task automatic issue(input bit wr, input int line, input int node);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr;
    reqLine = LINE_W'(line); reqNode = NODE_W'(node);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic pulseResume();
    @(negedge clk); resumeValid = 1'b1;
    @(posedge clk); @(negedge clk); resumeValid = 1'b0;
  endtask

  task automatic pulseWb();
    @(negedge clk); wbValid = 1'b1;
    @(posedge clk); @(negedge clk); wbValid = 1'b0;
  endtask

  task automatic pulseAck();
    @(negedge clk); ackValid = 1'b1;
    @(posedge clk); @(negedge clk); ackValid = 1'b0;
  endtask

  task automatic expectGrant(input string tag, input bit wr, input int node);
    chk({tag, " grantValid"}, grantValid, 1);
    chk({tag, " grantWrite"}, grantWrite, wr);
    chk({tag, " grantNode"}, grantNode, node);
  endtask

  task automatic expectTrap(input string tag, input bit ovf, input int line, input int node);
    chk({tag, " trapValid"}, trapValid, 1);
    chk({tag, " trapOverflow"}, trapOverflow, ovf);
    chk({tag, " trapLine"}, trapLine, line);
    chk({tag, " trapNode"}, trapNode, node);
    chk({tag, " no grant"}, grantValid, 0);
    chk({tag, " reqReady"}, reqReady, 0);
  endtask

  task automatic testReset();
    chk("R10 reqReady", reqReady, 1);
    chk("R10 grantValid", grantValid, 0);
    chk("R10 trapValid", trapValid, 0);
    chk("R10 invValid", invValid, 0);
    chk("R10 fetchValid", fetchValid, 0);
    chk("R10 trapOverflow", trapOverflow, 0);
  endtask

  task automatic testOverflow();
    for (int n = 1; n <= 4; n++) begin
      issue(0, 1, n);
      expectGrant("R1 read grant", 0, n);
    end
    step(1);
    chk("R1 grant is one cycle", grantValid, 0);
    issue(0, 1, 2);
    expectGrant("R6 repeat read", 0, 2);
    issue(0, 1, 5);
    expectTrap("R2 fifth reader", 1, 1, 5);
    step(3);
    chk("R2 trap held", trapValid, 1);
    chk("R9 not ready in trap", reqReady, 0);
    pulseResume();
    chk("R2 trap cleared", trapValid, 0);
    chk("R2 ready after resume", reqReady, 1);
  endtask

  task automatic testExtended();
    issue(0, 1, 1);
    expectTrap("R3 read extended", 0, 1, 1);
    pulseResume();
    issue(1, 1, 2);
    expectTrap("R3 write extended", 0, 1, 2);
    pulseResume();
    issue(0, 2, 1);
    expectGrant("R3 other line", 0, 1);
  endtask

  task automatic testInvalidate();
    for (int n = 1; n <= 3; n++) issue(0, 3, n);
    issue(1, 3, 2);
    chk("R5 first inval", invValid, 1);
    chk("R5 first inval node", invNode, 1);
    chk("R5 no early grant", grantValid, 0);
    chk("R9 not ready in inval", reqReady, 0);
    step(1);
    chk("R5 second inval", invValid, 1);
    chk("R5 second inval node", invNode, 3);
    step(1);
    chk("R5 invals done", invValid, 0);
    chk("R5 waits for acks", grantValid, 0);
    pulseAck();
    chk("R5 one ack short", grantValid, 0);
    pulseAck();
    chk("R5 grant not yet", grantValid, 0);
    step(1);
    expectGrant("R5 exclusive grant", 1, 2);
    issue(1, 3, 2);
    expectGrant("R8 owner rewrite", 1, 2);
    chk("R8 no inval", invValid, 0);
    // read from another node: fetch from owner
    issue(0, 3, 5);
    chk("R7 fetchValid", fetchValid, 1);
    chk("R7 fetchNode", fetchNode, 2);
    chk("R7 no grant", grantValid, 0);
    // request while busy must be ignored
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqLine = 3'd2; reqNode = 4'd9;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    chk("R9 busy request ignored", grantValid, 0);
    chk("R7 fetch held", fetchValid, 1);
    pulseWb();
    expectGrant("R7 read after wb", 0, 5);
    chk("R7 fetch cleared", fetchValid, 0);
    step(1);
    chk("R9 no grant for ignored", grantValid, 0);
    chk("R9 no trap for ignored", trapValid, 0);
    chk("R9 ready", reqReady, 1);
    // merged sharers: owner then requester
    issue(1, 3, 7);
    chk("R7 merged slot0", invNode, 2);
    step(1);
    chk("R7 merged slot1", invNode, 5);
    pulseAck();
    pulseAck();
    step(1);
    expectGrant("R5 grant after merge", 1, 7);
  endtask

  task automatic testImmediateWrite();
    issue(1, 4, 6);
    expectGrant("R8 write uncached", 1, 6);
    chk("R8 no inval uncached", invValid, 0);
    issue(0, 5, 3);
    issue(1, 5, 3);
    expectGrant("R8 sole sharer write", 1, 3);
    chk("R8 no inval sole", invValid, 0);
  endtask

  task automatic testZeroPtr();
    zeroPtrMode = 1'b1;
    issue(0, 6, 1);
    expectTrap("R4 zero read", 0, 6, 1);
    pulseResume();
    issue(1, 4, 9);
    expectTrap("R4 zero write", 0, 4, 9);
    pulseResume();
    zeroPtrMode = 1'b0;
    issue(0, 4, 1);
    chk("R4 entry unchanged fetch", fetchValid, 1);
    chk("R4 entry unchanged owner", fetchNode, 6);
    pulseWb();
    expectGrant("R4 read after wb", 0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(1);
    testReset();
    testOverflow();
    testExtended();
    testInvalidate();
    testImmediateWrite();
    testZeroPtr();
    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule